// File: doc/BRIEF.md
# Link Power Mode Controller

This block chooses the working state of a video link repeater and drives the enables of the repeater's sub-blocks from that state. The three states are power-down, standby and normal operation. The choice depends on the output-enable pin, the downstream hot-plug level, whether the input clock is valid, whether the repeater runs as a retimer or a redriver, whether signal detection is enabled, and a software power-down bit.

The block also holds a tiny configuration store. That store keeps the software power-down bit and the clock-ratio status bit. Both bits are written through a byte-wide write port. Each time the output-enable pin rises, the store is wiped and a one-cycle clear pulse goes to the rest of the register file. Software must therefore program the store again after every wake-up from the pin.

The hot-plug and clock-valid inputs pass through two synchroniser flops. The state register then takes one further cycle to follow them. The output-enable pin gates every enable directly, so pulling it low shuts the link off in the same cycle.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, mode_o is 2'b00, every enable is low, cfg_clr_o is low and clk_ratio_o is 0.
- R2: When oe_i is low, mode_o reads 2'b00 and rx_data_en_o, rx_clk_en_o, tx_en_o, ddc_en_o and arc_en_o are all low in that same cycle, whatever the other inputs are.
- R3: A rising edge on oe_i makes cfg_clr_o high for exactly one cycle, in the cycle after the edge is sampled. At that same edge the power-down bit and clk_ratio_o are cleared, and this clear wins over a write in the same cycle.
- R4: Writing a byte to address 8'h09 with bit 3 set forces power-down. This takes effect from the second clock edge after the write, even with oe_i and hot-plug both high. Writing bit 3 as 0 releases it.
- R5: With oe_i high and the synchronised hot-plug low, the state is power-down (2'b00) with all enables low.
- R6: hpd_src_o equals hpd_snk_i delayed by two clock cycles, in every state, including while oe_i is low.
- R7: Standby (mode 2'b01) is entered when hot-plug is high, the clock is not valid, and either retimer_sel_i or sig_det_en_i is 1. In standby only rx_clk_en_o, ddc_en_o and arc_en_o are high.
- R8: With hot-plug high and the synchronised clock valid, the state is normal (2'b10) and all five enables are high.
- R9: With retimer_sel_i = 0 (redriver) and sig_det_en_i = 0, hot-plug high gives the normal state even when the clock is not valid.
- R10: A change on hpd_snk_i or clk_valid_i shows on mode_o after the third rising clock edge: two synchroniser edges, then one state-register edge.
- R11: Writing a byte to address 8'h20 loads clk_ratio_o from bit 1 of the data. Writes to other addresses leave both stored bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_i | input | 1 | Output-enable pin |
| hpd_snk_i | input | 1 | Downstream hot-plug level (asynchronous) |
| sig_det_en_i | input | 1 | Signal-detect enable |
| clk_valid_i | input | 1 | Input clock valid (asynchronous) |
| retimer_sel_i | input | 1 | 1 = retimer, 0 = redriver |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| hpd_src_o | output | 1 | Upstream hot-plug level |
| rx_data_en_o | output | 1 | Receive data-lane enable |
| rx_clk_en_o | output | 1 | Receive clock-lane enable |
| tx_en_o | output | 1 | Transmit enable (low = outputs high impedance) |
| ddc_en_o | output | 1 | Display data channel enable |
| arc_en_o | output | 1 | Audio return channel enable |
| cfg_clr_o | output | 1 | One-cycle register-file clear |
| clk_ratio_o | output | 1 | Stored clock-ratio status bit |
| mode_o | output | 2 | 00 power-down, 01 standby, 10 normal |

## Verification
The bench builds the block with its default parameters: an 8-bit address and data port, the power-down bit at 8'h09 bit 3, the ratio bit at 8'h20 bit 1, and two synchroniser stages. With only two stages, every hot-plug or clock change reaches mode_o within three edges. Random stimulus that holds each input for a few cycles can therefore reach every state transition, including a pin rise that lands on a write cycle. Directed sequences then pin down reset, the three-edge latency, and the release of a software power-down.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    typedef enum logic [1:0] {
        PM_DOWN = 2'b00,
        PM_STBY = 2'b01,
        PM_NORM = 2'b10
    } pwr_mode_e;

    typedef struct packed {
        logic rx_data;
        logic rx_clk;
        logic tx;
        logic ddc;
        logic arc;
    } lane_en_t;

    function automatic pwr_mode_e pick_mode(
        input logic pin_on,
        input logic sw_off,
        input logic plug,
        input logic clk_ok,
        input logic det_en,
        input logic retime
    );
        if (!pin_on || sw_off || !plug) return PM_DOWN;
        if (clk_ok)                     return PM_NORM;
        if (!retime && !det_en)         return PM_NORM;
        return PM_STBY;
    endfunction

    function automatic lane_en_t decode_en(input pwr_mode_e m);
        lane_en_t e;
        e = '0;
        case (m)
            PM_NORM: e = '{rx_data: 1'b1, rx_clk: 1'b1, tx: 1'b1, ddc: 1'b1, arc: 1'b1};
            PM_STBY: e = '{rx_data: 1'b0, rx_clk: 1'b1, tx: 1'b0, ddc: 1'b1, arc: 1'b1};
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lpc_cfg_store.sv
module lpc_cfg_store #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter logic [7:0]  PD_ADDR   = 8'h09,
    parameter int          PD_BIT    = 3,
    parameter logic [7:0]  RATIO_ADDR = 8'h20,
    parameter int          RATIO_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              sw_pd_o,
    output logic              ratio_o
);
    localparam logic [ADDR_W-1:0] PD_A = ADDR_W'(PD_ADDR);
    localparam logic [ADDR_W-1:0] RT_A = ADDR_W'(RATIO_ADDR);

    always_ff @(posedge clk) begin
        if (rst || wipe_i) begin
            sw_pd_o <= 1'b0;
            ratio_o <= 1'b0;
        end else if (we_i) begin
            if (addr_i == PD_A) sw_pd_o <= wdata_i[PD_BIT];
            if (addr_i == RT_A) ratio_o <= wdata_i[RATIO_BIT];
        end
    end
endmodule

// File: rtl/lpc_mode_fsm.sv
module lpc_mode_fsm
    import lpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_on_i,
    input  logic      sw_pd_i,
    input  logic      plug_i,
    input  logic      clk_ok_i,
    input  logic      det_en_i,
    input  logic      retime_i,
    output pwr_mode_e mode_o
);
    pwr_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= PM_DOWN;
        else     mode_q <= pick_mode(pin_on_i, sw_pd_i, plug_i, clk_ok_i, det_en_i, retime_i);
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
    import lpc_pkg::*;
#(
    parameter int         ADDR_W     = 8,
    parameter int         DATA_W     = 8,
    parameter logic [7:0] PD_ADDR    = 8'h09,
    parameter int         PD_BIT     = 3,
    parameter logic [7:0] RATIO_ADDR = 8'h20,
    parameter int         RATIO_BIT  = 1,
    parameter int         SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              oe_i,
    input  logic              hpd_snk_i,
    input  logic              sig_det_en_i,
    input  logic              clk_valid_i,
    input  logic              retimer_sel_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic              hpd_src_o,
    output logic              rx_data_en_o,
    output logic              rx_clk_en_o,
    output logic              tx_en_o,
    output logic              ddc_en_o,
    output logic              arc_en_o,
    output logic              cfg_clr_o,
    output logic              clk_ratio_o,
    output logic [1:0]        mode_o
);
    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] raw_in, synced;
    logic              plug_s, clk_s;
    logic              oe_q, oe_rise, clr_q;
    logic              sw_pd;
    pwr_mode_e         mode_q;
    lane_en_t          en;

    assign raw_in = {clk_valid_i, hpd_snk_i};

    lpc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (synced)
    );

    assign plug_s = synced[0];
    assign clk_s  = synced[1];

    assign oe_rise = oe_i && !oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q  <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            oe_q  <= oe_i;
            clr_q <= oe_rise;
        end
    end

    lpc_cfg_store #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PD_ADDR    (PD_ADDR),
        .PD_BIT     (PD_BIT),
        .RATIO_ADDR (RATIO_ADDR),
        .RATIO_BIT  (RATIO_BIT)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wipe_i  (oe_rise),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .sw_pd_o (sw_pd),
        .ratio_o (clk_ratio_o)
    );

    lpc_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pin_on_i (oe_i),
        .sw_pd_i  (sw_pd),
        .plug_i   (plug_s),
        .clk_ok_i (clk_s),
        .det_en_i (sig_det_en_i),
        .retime_i (retimer_sel_i),
        .mode_o   (mode_q)
    );

    always_comb begin
        en = decode_en(mode_q);
        if (!oe_i) en = '0;
    end

    assign hpd_src_o    = plug_s;
    assign rx_data_en_o = en.rx_data;
    assign rx_clk_en_o  = en.rx_clk;
    assign tx_en_o      = en.tx;
    assign ddc_en_o     = en.ddc;
    assign arc_en_o     = en.arc;
    assign cfg_clr_o    = clr_q;
    assign mode_o       = oe_i ? mode_q : PM_DOWN;
endmodule

// File: rtl/link_pwr_ctrl_chk.sv
module link_pwr_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       oe_i,
    input logic       hpd_src_o,
    input logic       rx_data_en_o,
    input logic       rx_clk_en_o,
    input logic       tx_en_o,
    input logic       ddc_en_o,
    input logic       arc_en_o,
    input logic       cfg_clr_o,
    input logic       clk_ratio_o,
    input logic [1:0] mode_o
);
    // R2
    oe_low_off_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_i |-> (mode_o == 2'b00) && !rx_data_en_o && !rx_clk_en_o && !tx_en_o && !ddc_en_o && !arc_en_o);

    // R3
    clr_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_clr_o |=> !cfg_clr_o);

    // R3
    clr_wiped_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_clr_o |-> !clk_ratio_o);

    // R5
    unplugged_down_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_i && $past(oe_i) && !$past(hpd_src_o)) |-> (mode_o == 2'b00));

    // R7
    standby_enables_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b01) |-> rx_clk_en_o && ddc_en_o && arc_en_o && !rx_data_en_o && !tx_en_o);

    // R8
    normal_enables_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10) |-> rx_clk_en_o && ddc_en_o && arc_en_o && rx_data_en_o && tx_en_o);

    // R8
    legal_mode_chk: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'b11);
endmodule

bind link_pwr_ctrl link_pwr_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .oe_i         (oe_i),
    .hpd_src_o    (hpd_src_o),
    .rx_data_en_o (rx_data_en_o),
    .rx_clk_en_o  (rx_clk_en_o),
    .tx_en_o      (tx_en_o),
    .ddc_en_o     (ddc_en_o),
    .arc_en_o     (arc_en_o),
    .cfg_clr_o    (cfg_clr_o),
    .clk_ratio_o  (clk_ratio_o),
    .mode_o       (mode_o)
);

// File: tb/link_pwr_ctrl_tb.sv
module link_pwr_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       oe = 1'b0, hpd = 1'b0, sig_en = 1'b0, cval = 1'b0, retime = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic       hpd_src, rxd, rxc, tx, ddc, arc, clr, ratio;
    logic [1:0] mode;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_pwr_ctrl u_dut (
        .clk(clk), .rst(rst), .oe_i(oe), .hpd_snk_i(hpd), .sig_det_en_i(sig_en),
        .clk_valid_i(cval), .retimer_sel_i(retime), .cfg_we_i(we), .cfg_addr_i(addr),
        .cfg_wdata_i(wdata), .hpd_src_o(hpd_src), .rx_data_en_o(rxd), .rx_clk_en_o(rxc),
        .tx_en_o(tx), .ddc_en_o(ddc), .arc_en_o(arc), .cfg_clr_o(clr),
        .clk_ratio_o(ratio), .mode_o(mode)
    );

    // reference state built from the requirements
    logic       h1, h2, c1, c2, oe_m, clr_m, pd_m, rt_m;
    logic [1:0] mode_m;

    function automatic logic [1:0] exp_mode(input logic o, p, h, c, s, r);
        if (!o || p || !h) return 2'b00;
        if (c)             return 2'b10;
        if (!r && !s)      return 2'b10;
        return 2'b01;
    endfunction

    function automatic logic [4:0] exp_en(input logic [1:0] m);
        // {rx_data, rx_clk, tx, ddc, arc}
        case (m)
            2'b10:   return 5'b11111;
            2'b01:   return 5'b01011;
            default: return 5'b00000;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            h1 <= 0; h2 <= 0; c1 <= 0; c2 <= 0;
            oe_m <= 0; clr_m <= 0; pd_m <= 0; rt_m <= 0; mode_m <= 2'b00;
        end else begin
            h1 <= hpd; h2 <= h1; c1 <= cval; c2 <= c1;
            oe_m <= oe; clr_m <= oe && !oe_m;
            if (oe && !oe_m) begin
                pd_m <= 0; rt_m <= 0;
            end else if (we) begin
                if (addr == 8'h09) pd_m <= wdata[3];
                if (addr == 8'h20) rt_m <= wdata[1];
            end
            mode_m <= exp_mode(oe, pd_m, h2, c2, sig_en, retime);
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag();
        logic [1:0] e;
        e = oe ? mode_m : 2'b00;
        if (!oe)                 return "R2";
        if (e == 2'b00 && pd_m)  return "R4";
        if (e == 2'b00)          return "R5";
        if (e == 2'b01)          return "R7";
        if (c2)                  return "R8";
        return "R9";
    endfunction

    task automatic check_all();
        logic [1:0] em;
        em = oe ? mode_m : 2'b00;
        chk(mode_tag(), {6'd0, mode}, {6'd0, em});
        chk(mode_tag(), {3'd0, rxd, rxc, tx, ddc, arc}, {3'd0, exp_en(em)});
        chk("R6", {7'd0, hpd_src}, {7'd0, h2});
        chk("R3", {7'd0, clr}, {7'd0, clr_m});
        chk("R11", {7'd0, ratio}, {7'd0, rt_m});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        we = 1; addr = a; wdata = d;
        step();
        we = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        oe = 1; hpd = 1; cval = 1; sig_en = 1; retime = 1;
        step(); step();
        // R1: reset state held
        chk("R1", {6'd0, mode}, 8'h00);
        chk("R1", {3'd0, rxd, rxc, tx, ddc, arc}, 8'h00);
        chk("R1", {6'd0, clr, ratio}, 8'h00);
        @(negedge clk) rst = 0;
        // first cycle after reset: R1
        chk("R1", {6'd0, mode}, 8'h00);
        step();
        // oe was high through reset, first edge after reset sees a rise: R3
        chk("R3", {7'd0, clr}, 8'h01);
        step();
        chk("R3", {7'd0, clr}, 8'h00);
        step(); step();
        chk("R8", {6'd0, mode}, 8'h02);

        // R10: drop the clock valid, retimer -> standby after third edge
        cval = 0;
        step(); step();
        chk("R10", {6'd0, mode}, 8'h02);
        step();
        chk("R10", {6'd0, mode}, 8'h01);

        // R9: redriver with detection off goes normal without clock
        retime = 0; sig_en = 0;
        step();
        chk("R9", {6'd0, mode}, 8'h02);

        // R11 and R4
        wr(8'h20, 8'h02);
        chk("R11", {7'd0, ratio}, 8'h01);
        wr(8'h33, 8'hFF);
        chk("R11", {7'd0, ratio}, 8'h01);
        wr(8'h09, 8'h08);
        chk("R4", {6'd0, mode}, 8'h02);
        step();
        chk("R4", {6'd0, mode}, 8'h00);
        chk("R4", {3'd0, rxd, rxc, tx, ddc, arc}, 8'h00);
        wr(8'h09, 8'h00);
        step();
        chk("R4", {6'd0, mode}, 8'h02);

        // R2: oe low with everything else high
        cval = 1; retime = 1; sig_en = 1;
        step(); step(); step();
        oe = 0;
        #1;
        chk("R2", {6'd0, mode}, 8'h00);
        chk("R2", {3'd0, rxd, rxc, tx, ddc, arc}, 8'h00);
        step();
        // R3: rise clears ratio even with a write on the same edge
        oe = 1; we = 1; addr = 8'h20; wdata = 8'h02;
        step();
        we = 0;
        chk("R3", {6'd0, clr, ratio}, 8'h02);
        step();
        chk("R3", {7'd0, clr}, 8'h00);

        // random phase with model comparison every cycle
        for (int i = 0; i < 3000; i++) begin
            check_all();
            if ($urandom_range(15) == 0) oe = ~oe;
            if ($urandom_range(9) == 0) hpd = ~hpd;
            if ($urandom_range(7) == 0) cval = ~cval;
            if ($urandom_range(39) == 0) sig_en = ~sig_en;
            if ($urandom_range(39) == 0) retime = ~retime;
            we = ($urandom_range(11) == 0);
            case ($urandom_range(2))
                0: addr = 8'h09;
                1: addr = 8'h20;
                default: addr = 8'($urandom_range(255));
            endcase
            wdata = 8'($urandom_range(255));
            if (addr == 8'h09 && $urandom_range(2) != 0) wdata[3] = 1'b0;
            step();
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule